// File: doc/BRIEF.md
# Forty-Bit Multiply-Accumulate Accumulator

This block holds one 40-bit signed accumulator for a coprocessor-style datapath. Each valid command either adds a signed product formed from two 32-bit register operands to the accumulator or loads the accumulator from a pair of 32-bit words. Three product forms are available. The first is a full 32x32 signed multiply. The second adds two halfword products at once, pairing the upper halves of the operands together and the lower halves together. The third multiplies one selectable signed halfword from each operand.

The accumulator value is always visible on two 32-bit read-back words. The low word carries bits 31:0. The high word carries bits 39:32, sign-extended to 32 bits. Instruction decode and register file write-back sit outside this block. The surrounding pipeline presents the operand values and a 2-bit command code together with a valid strobe.

Top module: `mac40_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to zero. The reset takes priority over any command in the same cycle.
- R2: Command code 0 (full) adds the product of operand A and operand B to the accumulator, with both operands taken as signed 32-bit values.
- R3: Command code 1 (dual) adds A[31:16]*B[31:16] plus A[15:0]*B[15:0] to the accumulator in a single step, with every halfword taken as signed 16-bit. The select inputs have no effect on this command.
- R4: Command code 2 (single) multiplies one signed halfword of A by one signed halfword of B and adds the product. Select input sel_a chooses the halfword of A and sel_b chooses the halfword of B, where 1 means bits 31:16 and 0 means bits 15:0.
- R5: Command code 3 (load) sets accumulator bits 31:0 to operand A and bits 39:32 to B[7:0]. Bits B[31:8] are ignored.
- R6: rd_lo always equals accumulator bits 31:0. rd_hi always equals accumulator bits 39:32, sign-extended from bit 39 to 32 bits.
- R7: A command takes effect on the clock edge that samples cmd_valid high. During that cycle the read-back words still show the previous value. When cmd_valid is low, the accumulator holds its value.
- R8: Additions wrap modulo 2^40. There is no saturation and no overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 full, 1 dual, 2 single, 3 load |
| op_a | input | 32 | Operand A; low word for load |
| op_b | input | 32 | Operand B; upper byte source for load |
| sel_a | input | 1 | Halfword select for A in single mode (1 = upper) |
| sel_b | input | 1 | Halfword select for B in single mode (1 = upper) |
| rd_lo | output | 32 | Accumulator bits 31:0 |
| rd_hi | output | 32 | Accumulator bits 39:32, sign-extended |

## Verification
The bench targets five corner cases.

- Negative products, where a design that zero-extends an operand or a halfword would add a large positive value instead of a negative one.
- All four select combinations of the single command, plus dual commands issued with the selects toggled, which expose swapped or leaking select logic.
- A load with junk in B[31:8], which catches a design that keeps more than eight upper bits.
- Increments across the 2^39 and 2^40 boundaries, which catch saturation or a wrong width, and which also show rd_hi flipping between 0x0000007F and 0xFFFFFF80.
- A long random command mix checked on every clock, plus a reset that coincides with a valid command, which catches an early update or the wrong priority between reset and a command.

// File: rtl/mac40_pkg.sv
package mac40_pkg;
  typedef enum logic [1:0] {
    MAC_FULL = 2'd0,
    MAC_DUAL = 2'd1,
    MAC_HALF = 2'd2,
    MAC_LOAD = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mac40_prod.sv
module mac40_prod
  import mac40_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 40
) (
  input  mac_op_e                op,
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  input  logic                   sel_a,
  input  logic                   sel_b,
  output logic [AW-1:0]          addend
);
  localparam int HW  = DW / 2;
  localparam int PW  = 2 * HW;
  localparam int FW  = 2 * DW;
  localparam int NL  = 2;

  logic signed [PW-1:0] lane_p [NL];
  logic [AW-1:0]        lane_x [NL];

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      assign lane_p[g] = $signed(a[g*HW +: HW]) * $signed(b[g*HW +: HW]);
      assign lane_x[g] = {{(AW-PW){lane_p[g][PW-1]}}, lane_p[g]};
    end
  endgenerate

  logic [HW-1:0]        ha, hb;
  logic signed [PW-1:0] one_p;
  logic [AW-1:0]        one_x;
  logic signed [FW-1:0] full_p;

  assign ha     = sel_a ? a[DW-1:HW] : a[HW-1:0];
  assign hb     = sel_b ? b[DW-1:HW] : b[HW-1:0];
  assign one_p  = $signed(ha) * $signed(hb);
  assign one_x  = {{(AW-PW){one_p[PW-1]}}, one_p};
  assign full_p = $signed(a) * $signed(b);

  always_comb begin
    case (op)
      MAC_FULL: addend = full_p[AW-1:0];
      MAC_DUAL: addend = lane_x[0] + lane_x[1];
      MAC_HALF: addend = one_x;
      default:  addend = '0;
    endcase
  end
endmodule

// File: rtl/mac40_acc.sv
module mac40_acc #(
  parameter int DW = 32,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic          load_en,
  input  logic [AW-1:0] addend,
  input  logic [DW-1:0] ld_lo,
  input  logic [DW-1:0] ld_hi,
  output logic [AW-1:0] acc
);
  localparam int EXT = AW - DW;

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (load_en) acc <= {ld_hi[EXT-1:0], ld_lo};
    else if (upd_en)  acc <= acc + addend;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> acc == '0);

  a_r5_load_low_byte: assert property (@(posedge clk) disable iff (rst)
    load_en |=> acc == {$past(ld_hi[EXT-1:0]), $past(ld_lo)});

  a_r8_wrap_add: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !load_en) |=> acc == AW'($past(acc) + $past(addend)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && !load_en) |=> $stable(acc));
endmodule

// File: rtl/mac40_rdback.sv
module mac40_rdback #(
  parameter int DW = 32,
  parameter int AW = 40
) (
  input  logic [AW-1:0] acc,
  output logic [DW-1:0] rd_lo,
  output logic [DW-1:0] rd_hi
);
  localparam int EXT = AW - DW;

  assign rd_lo = acc[DW-1:0];
  assign rd_hi = {{(DW-EXT){acc[AW-1]}}, acc[AW-1:DW]};
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          sel_a,
  input  logic          sel_b,
  output logic [DW-1:0] rd_lo,
  output logic [DW-1:0] rd_hi
);
  mac_op_e       op;
  logic [AW-1:0] addend;
  logic [AW-1:0] acc;
  logic          load_en, upd_en;

  assign op      = mac_op_e'(cmd_op);
  assign load_en = cmd_valid && (op == MAC_LOAD);
  assign upd_en  = cmd_valid && (op != MAC_LOAD);

  mac40_prod #(.DW(DW), .AW(AW)) u_prod (
    .op(op), .a(op_a), .b(op_b), .sel_a(sel_a), .sel_b(sel_b), .addend(addend)
  );

  mac40_acc #(.DW(DW), .AW(AW)) u_acc (
    .clk(clk), .rst(rst), .upd_en(upd_en), .load_en(load_en),
    .addend(addend), .ld_lo(op_a), .ld_hi(op_b), .acc(acc)
  );

  mac40_rdback #(.DW(DW), .AW(AW)) u_rd (
    .acc(acc), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  a_r7_read_old_value: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (rd_lo == $past(rd_lo)) && (rd_hi == $past(rd_hi)));
endmodule

// File: tb/sim_mac40_unit.sv
module sim_mac40_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sel_a = 1'b0, sel_b = 1'b0;
  logic [31:0] rd_lo, rd_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [39:0] m_acc = '0;

  always #2 clk = ~clk;

  mac40_unit u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b),
    .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // R6: compare both read-back words against the model
  task automatic compare(string req);
    chk({req, " R6 lo"}, rd_lo, m_acc[31:0]);
    chk({req, " R6 hi"}, rd_hi, {{24{m_acc[39]}}, m_acc[39:32]});
  endtask

  function automatic logic [39:0] model_add(logic [1:0] op, logic [31:0] a,
      logic [31:0] b, logic sa, logic sb);
    longint p;
    logic [15:0] ha, hb;
    case (op)
      2'd0: p = longint'($signed(a)) * longint'($signed(b));
      2'd1: p = longint'($signed(a[31:16])) * longint'($signed(b[31:16]))
              + longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
      default: begin
        ha = sa ? a[31:16] : a[15:0];
        hb = sb ? b[31:16] : b[15:0];
        p  = longint'($signed(ha)) * longint'($signed(hb));
      end
    endcase
    return p[39:0];
  endfunction

  // One clock: check old state, drive, check unchanged same cycle (R7), update model.
  task automatic step(string req, logic v, logic [1:0] op, logic [31:0] a,
                      logic [31:0] b, logic sa, logic sb, logic r = 1'b0);
    @(negedge clk);
    compare(req);
    rst = r; cmd_valid = v; cmd_op = op; op_a = a; op_b = b; sel_a = sa; sel_b = sb;
    #1;
    compare({req, " R7 same-cycle"});
    @(posedge clk);
    if (r)            m_acc = '0;
    else if (v && op == 2'd3) m_acc = {b[7:0], a};
    else if (v)       m_acc = m_acc + model_add(op, a, b, sa, sb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    m_acc = '0;
    @(negedge clk);
    rst = 1'b0;
    compare("R1 reset");
    // R2 full multiply, positive and negative
    step("R2", 1, 2'd0, 32'd1000, 32'd3000, 0, 0);
    step("R2", 1, 2'd0, 32'hFFFF_FFFF, 32'd7, 0, 0);
    step("R2", 1, 2'd0, 32'h8000_0000, 32'h8000_0000, 0, 0);
    step("R2", 1, 2'd0, 32'h8000_0000, 32'h7FFF_FFFF, 1, 1);
    // R7 idle hold
    step("R7 idle", 0, 2'd0, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0);
    step("R7 idle", 0, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
    // R5 load with junk upper bits
    step("R5", 1, 2'd3, 32'hDEAD_BEEF, 32'hABCD_EF12, 0, 0);
    step("R5", 1, 2'd3, 32'h0, 32'h0, 0, 0);
    // R3 dual with selects toggled
    step("R3", 1, 2'd1, 32'hFFFE_0003, 32'h0005_FFF9, 0, 0);
    step("R3", 1, 2'd1, 32'h8000_8000, 32'h8000_8000, 1, 1);
    step("R3", 1, 2'd1, 32'h7FFF_8000, 32'h8000_7FFF, 1, 0);
    // R4 single, all select combinations
    step("R4", 1, 2'd2, 32'h0003_FFFB, 32'hFFF9_0011, 0, 0);
    step("R4", 1, 2'd2, 32'h0003_FFFB, 32'hFFF9_0011, 0, 1);
    step("R4", 1, 2'd2, 32'h0003_FFFB, 32'hFFF9_0011, 1, 0);
    step("R4", 1, 2'd2, 32'h0003_FFFB, 32'hFFF9_0011, 1, 1);
    // R8 wrap across 2^39 and 2^40
    step("R8", 1, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FF7F, 0, 0);
    step("R8", 1, 2'd0, 32'd1, 32'd1, 0, 0);
    step("R8", 1, 2'd3, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0);
    step("R8", 1, 2'd0, 32'd1, 32'd1, 0, 0);
    step("R8", 1, 2'd0, 32'hFFFF_FFFF, 32'd1, 0, 0);
    // R1 reset wins over a valid command
    step("R1 prio", 1, 2'd3, 32'h1111_1111, 32'h22, 0, 0);
    step("R1 prio", 1, 2'd0, 32'd5, 32'd5, 0, 0, 1'b1);
    step("R1 after", 0, 2'd0, 32'd0, 32'd0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      step("R2 R3 R4 R5 rand", ($urandom % 4) != 0, 2'($urandom), $urandom,
           $urandom, 1'($urandom), 1'($urandom));
    end
    step("final", 0, 2'd0, 32'd0, 32'd0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule